// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit is the signed saturating arithmetic slice of a processor datapath. Each cycle it may accept two register operands, a two-bit operation code, a four-bit condition code and the current N, Z, C and V flags. When the condition holds, it performs one of four operations:

- a saturating add,
- a saturating subtract,
- a saturating add of a doubled second operand,
- a saturating subtract of a doubled second operand.

One cycle later it presents the clamped result together with a write-enable for the destination register.

Every clamp ORs a sticky saturation bit, Q, to 1. The doubling operations can clamp at two points: once when the second operand is doubled, and again on the final add or subtract. Either clamp sets Q. A separate clear input resets Q, for use when software writes the status register. The surrounding pipeline handles register reads, instruction fetch and all other decode.

Top module: `qsat_unit`

## Requirements
- R1: With op_i = 2'b00 the result is rm_i + rn_i as signed values. A result above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and a result below 0x80000000 is replaced by 0x80000000.
- R2: With op_i = 2'b01 the result is rm_i − rn_i, clamped to the same two limits.
- R3: With op_i = 2'b10 the unit first forms 2·rn_i and clamps it to the 32-bit signed range. It then adds that value to rm_i and clamps the sum.
- R4: With op_i = 2'b11 the unit forms the clamped 2·rn_i as in R3. It then subtracts that value from rm_i and clamps the difference.
- R5: Any clamp in an executed operation sets q_o to 1 in the cycle after that operation. This includes a clamp only at the doubling step. q_o stays 1 until it is cleared.
- R6: q_clr_i = 1 makes q_o 0 on the next cycle. This holds even when an executed operation clamps in the same cycle.
- R7: Each code on cond_i is tested against flags_i = {N,Z,C,V}. The codes are 0 EQ Z, 1 NE !Z, 2 CS C, 3 CC !C, 4 MI N, 5 PL !N, 6 VS V, 7 VC !V, 8 HI C&!Z, 9 LS !C|Z, 10 GE N==V, 11 LT N!=V, 12 GT !Z&(N==V), 13 LE Z|(N!=V), 14 always and 15 never. When the test fails, wr_en_o is 0 on the next cycle, result_o holds its value and q_o is unchanged.
- R8: result_o and wr_en_o follow an accepted operation by one clock cycle. In a cycle with valid_i = 0, the next cycle has wr_en_o = 0, result_o held and Q not set.
- R9: While rst_ni is low, result_o, wr_en_o and q_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Operation select (add, sub, doubled add, doubled sub) |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| rm_i | input | 32 | First operand |
| rn_i | input | 32 | Second operand (doubled in ops 2 and 3) |
| q_clr_i | input | 1 | Clear sticky saturation bit |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable, registered |
| q_o | output | 1 | Sticky saturation bit |

## Verification
The hardest case to reach from the ports is a doubling operation where only the doubling clamps and the final add or subtract does not. An example is rn_i = 0x40000000, which doubles to 0x7FFFFFFF after the clamp, with rm_i = −1, which brings the sum back into range. In that case the only sign of the first clamp is Q.

The bench sweeps all four operations over every pair drawn from a set of operand extremes and near-extremes: the two limits, 0, −1, 1, ±2^30 and 2^30−1. It clears Q before each operation, so the Q seen afterwards belongs to that operation alone. Expected values come from a 64-bit model that clamps twice.

The condition logic is covered by a full 16×16 sweep of codes against flag patterns. A clamping operation issued together with a clear checks that the clear has priority.

// File: rtl/qsat_pkg.sv
package qsat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  // flag vector bit positions
  localparam int unsigned FL_N = 3;
  localparam int unsigned FL_Z = 2;
  localparam int unsigned FL_C = 1;
  localparam int unsigned FL_V = 0;
endpackage

// File: rtl/qsat_cond.sv
module qsat_cond
  import qsat_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  logic n, z, c, v;
  assign n = flags_i[FL_N];
  assign z = flags_i[FL_Z];
  assign c = flags_i[FL_C];
  assign v = flags_i[FL_V];

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ: pass_o = z;
      CC_NE: pass_o = !z;
      CC_CS: pass_o = c;
      CC_CC: pass_o = !c;
      CC_MI: pass_o = n;
      CC_PL: pass_o = !n;
      CC_VS: pass_o = v;
      CC_VC: pass_o = !v;
      CC_HI: pass_o = c && !z;
      CC_LS: pass_o = !c || z;
      CC_GE: pass_o = (n == v);
      CC_LT: pass_o = (n != v);
      CC_GT: pass_o = !z && (n == v);
      CC_LE: pass_o = z || (n != v);
      CC_AL: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

  always_comb begin
    if (cond_i == 4'hE) a_r7_always_passes: assert (pass_o);
    if (cond_i == 4'hF) a_r7_never_passes: assert (!pass_o);
  end
endmodule

// File: rtl/qsat_addsub.sv
module qsat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam int unsigned MSB = W - 1;
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] wrap;
  logic         ovf;

  always_comb begin
    wrap = sub_i ? (a_i - b_i) : (a_i + b_i);
    if (sub_i) ovf = (a_i[MSB] != b_i[MSB]) && (wrap[MSB] != a_i[MSB]);
    else       ovf = (a_i[MSB] == b_i[MSB]) && (wrap[MSB] != a_i[MSB]);
  end

  // wrapped sign 0 on overflow means true value was negative
  assign res_o = ovf ? (wrap[MSB] ? MAXV : MINV) : wrap;
  assign sat_o = ovf;

  always_comb begin
    if (sat_o) a_r1_clamp_at_limit: assert (res_o == MAXV || res_o == MINV);
  end
endmodule

// File: rtl/qsat_alu.sv
module qsat_alu
  import qsat_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] rm_i,
  input  logic [W-1:0] rn_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  logic [W-1:0] dbl, opb;
  logic         dbl_sat, fin_sat, use_dbl, do_sub;

  assign use_dbl = op_i[1];
  assign do_sub  = op_i[0];

  qsat_addsub #(.W(W)) u_dbl (
    .a_i(rn_i), .b_i(rn_i), .sub_i(1'b0), .res_o(dbl), .sat_o(dbl_sat)
  );

  assign opb = use_dbl ? dbl : rn_i;

  qsat_addsub #(.W(W)) u_fin (
    .a_i(rm_i), .b_i(opb), .sub_i(do_sub), .res_o(res_o), .sat_o(fin_sat)
  );

  assign sat_o = fin_sat || (use_dbl && dbl_sat);

  always_comb begin
    if (use_dbl && dbl_sat) a_r3_dbl_clamp_flags: assert (sat_o);
  end
endmodule

// File: rtl/qsat_unit.sv
module qsat_unit
  import qsat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic              q_clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              q_o
);
  logic              pass, exec, alu_sat;
  logic [DATA_W-1:0] alu_res;

  qsat_cond u_cond (.cond_i(cond_i), .flags_i(flags_i), .pass_o(pass));

  qsat_alu #(.W(DATA_W)) u_alu (
    .op_i(op_i), .rm_i(rm_i), .rn_i(rn_i), .res_o(alu_res), .sat_o(alu_sat)
  );

  assign exec = valid_i && pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= exec;
      if (exec) result_o <= alu_res;
    end
  end

  // clear beats set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (q_clr_i) q_o <= 1'b0;
    else if (exec && alu_sat) q_o <= 1'b1;
  end

  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_clr_i |=> !q_o);
  a_r5_q_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_clr_i) |=> q_o);
  a_r7_skip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> (!wr_en_o && $stable(result_o)));
  a_r5_q_only_on_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !(exec && alu_sat)) |=> !q_o);
  a_r8_wr_follows_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i));
endmodule

// File: tb/sim_qsat_unit.sv
module sim_qsat_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  cond_i = 4'hE;
  logic [3:0]  flags_i = '0;
  logic [31:0] rm_i = '0;
  logic [31:0] rn_i = '0;
  logic        q_clr_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic        q_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;
  logic        exp_q = 1'b0;

  qsat_unit u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic longint clampv(longint x, inout bit s);
    if (x > MAXV) begin s = 1'b1; return MAXV; end
    if (x < MINV) begin s = 1'b1; return MINV; end
    return x;
  endfunction

  function automatic logic [32:0] ref_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    bit s = 1'b0;
    longint av = longint'($signed(a));
    longint bv = longint'($signed(b));
    longint r;
    if (op[1]) bv = clampv(2 * bv, s);
    r = op[0] ? av - bv : av + bv;
    r = clampv(r, s);
    return {s, r[31:0]};
  endfunction

  function automatic bit ref_cond(logic [3:0] c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy && !z;   4'h9: return !cy || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, update model, sample after edge
  task automatic step(string req, bit vld, logic [1:0] op, logic [3:0] c,
                      logic [3:0] f, logic [31:0] a, logic [31:0] b, bit clr);
    logic [32:0] r;
    bit ex;
    @(negedge clk_i);
    valid_i = vld; op_i = op; cond_i = c; flags_i = f;
    rm_i = a; rn_i = b; q_clr_i = clr;
    r = ref_op(op, a, b);
    ex = vld && ref_cond(c, f);
    @(posedge clk_i);
    #1;
    if (ex) exp_res = r[31:0];
    if (clr) exp_q = 1'b0;
    else if (ex && r[32]) exp_q = 1'b1;
    chk(req, result_o, exp_res);
    chk(req, {31'b0, wr_en_o}, {31'b0, ex});
    chk(req, {31'b0, q_o}, {31'b0, exp_q});
  endtask

  logic [31:0] vals [8] = '{32'h7FFFFFFF, 32'h80000000, 32'h0, 32'hFFFFFFFF,
                            32'h1, 32'h40000000, 32'hC0000000, 32'h3FFFFFFF};

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(3 * CLK_PERIOD);
    // R9 reset state
    chk("R9", result_o, 32'h0);
    chk("R9", {31'b0, wr_en_o}, 32'h0);
    chk("R9", {31'b0, q_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5: sweep ops over extremes, clear Q before each
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          step("R5", 1'b0, 2'b00, 4'hE, 4'h0, 32'h0, 32'h0, 1'b1);
          case (op)
            0: step("R1", 1'b1, 2'(op), 4'hE, 4'h0, vals[i], vals[j], 1'b0);
            1: step("R2", 1'b1, 2'(op), 4'hE, 4'h0, vals[i], vals[j], 1'b0);
            2: step("R3", 1'b1, 2'(op), 4'hE, 4'h0, vals[i], vals[j], 1'b0);
            default: step("R4", 1'b1, 2'(op), 4'hE, 4'h0, vals[i], vals[j], 1'b0);
          endcase
        end
      end
    end

    // R3 only the doubling clamps: 0x40000000*2 -> 0x7FFFFFFF, + -1 fits
    step("R5", 1'b0, 2'b00, 4'hE, 4'h0, 32'h0, 32'h0, 1'b1);
    step("R3", 1'b1, 2'b10, 4'hE, 4'h0, 32'hFFFFFFFF, 32'h40000000, 1'b0);
    chk("R3", result_o, 32'h7FFFFFFE);
    chk("R3", {31'b0, q_o}, 32'h1);
    // R5 sticky across a non-saturating op
    step("R5", 1'b1, 2'b00, 4'hE, 4'h0, 32'h1, 32'h1, 1'b0);
    chk("R5", {31'b0, q_o}, 32'h1);
    // R6 clear beats set in the same cycle
    step("R6", 1'b1, 2'b00, 4'hE, 4'h0, 32'h7FFFFFFF, 32'h1, 1'b1);
    chk("R6", {31'b0, q_o}, 32'h0);

    // R8 valid low: no write, result held, Q not set by a clamping op
    step("R8", 1'b1, 2'b00, 4'hE, 4'h0, 32'h12345678, 32'h0, 1'b0);
    step("R8", 1'b0, 2'b00, 4'hE, 4'h0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    chk("R8", result_o, 32'h12345678);

    // R7 full condition sweep; failing op would clamp and set Q
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        step("R7", 1'b0, 2'b00, 4'hE, 4'h0, 32'h0, 32'h0, 1'b1);
        step("R7", 1'b1, 2'b00, 4'hE, 4'h0, 32'hA5A5A5A5, 32'h0, 1'b0);
        step("R7", 1'b1, 2'b00, 4'(c), 4'(f), 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule